// File: doc/BRIEF.md
# Self-Decimating Keystream Generator

This block produces a pseudo-random bit stream from a five-stage shift register with linear feedback. The bit it puts out also decides how far the register advances before the next bit. A 0 costs one register step and a 1 costs two. Discarding every other register output after each 1 breaks up the plain linear sequence cheaply, so the block suits lightweight stream-cipher style keystreams and scramblers.

A consumer loads a seed and then takes bits through a valid/ready handshake. A mode input, sampled at seed load, picks when the first bit appears:

- In seed-first mode, the first bit is the last stage of the seed itself.
- In the other mode, the register advances once before the first bit is offered.

The average output rate is below one bit per clock, because every emitted 1 costs an extra cycle with valid low. An all-zero seed is replaced by a fixed nonzero default, so the register can never lock up.

Top module: `selfdec_keygen`

## Requirements
- R1: After reset, keyValid is low and stays low until the first seed load, whatever keyReady does.
- R2: A register step shifts stage k into stage k+1 and puts into stage 1 the XOR of stages 2, 3, 4 and 5 (polynomial x^5+x^4+x^3+x^2+1). keyBit is always stage 5. seedIn bit 0 loads stage 1 and seedIn bit 4 loads stage 5.
- R3: A load with seedFirst=1 makes keyValid high in the next cycle, with keyBit equal to seedIn bit 4. From seed 11111 the first 20 bits are 1,1,1,0,1,0,1,0,0,0,0,1,1,0,1,1,0,0,1,1.
- R4: A load with seedFirst=0 keeps keyValid low for one cycle while the register steps once. The first valid bit is stage 5 after that step.
- R5: A bit is consumed on a cycle where keyValid and keyReady are both high. After a consumed 0 the register steps once and keyValid is high in the next cycle. After a consumed 1 it steps twice, and keyValid is low for exactly one cycle. From seed 11111 in seed-first mode, with keyReady held high, the 20th bit is consumed 30 cycles after the first valid cycle, counting both ends.
- R6: While keyValid is high and keyReady is low, the register holds, and keyBit and keyValid stay unchanged.
- R7: Loading seed 00000 loads the default seed 00001 instead, so the first bit in seed-first mode is 0. The register is never all zero.
- R8: A load in the same cycle as a consumed bit wins. The register takes the new seed without stepping, and first-bit sequencing restarts.
- R9: seedFirst is sampled only in a load cycle. Changing it at other times has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seedLoad | input | 1 | Strobe that loads seedIn into the register |
| seedIn | input | 5 | Seed value, bit 4 is the output stage |
| seedFirst | input | 1 | 1: first bit taken from the seed; 0: one step before the first bit |
| keyReady | input | 1 | Consumer accepts keyBit |
| keyBit | output | 1 | Current keystream bit (register stage 5) |
| keyValid | output | 1 | keyBit may be consumed |

## Verification
A seed load and a consumed bit can land in the same cycle. The load must win, with no register step, and the decimation count restarts. The bench provokes this directly by asserting seedLoad while keyValid and keyReady are both high. It chooses a case where a step would have exposed a different bit from the new seed's stage 5, and checks that the new seed's bit appears next. Random loads during a randomly stalled stream repeat the collision many times. A cycle model built from the requirements judges every cycle.

// File: rtl/keygen_pkg.sv
`timescale 1ns/1ps
package keygen_pkg;
  // Strobes from the sequencing control to the shift register.
  typedef struct packed {
    logic load;
    logic step;
  } keyStrobe_t;
endpackage

// File: rtl/keygen_datapath.sv
`timescale 1ns/1ps
module keygen_datapath
  import keygen_pkg::*;
#(
  parameter int              WIDTH        = 5,
  parameter logic [WIDTH-1:0] TAP_MASK     = 5'b11110,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 5'b00001
) (
  input  logic             clk,
  input  logic             rst,
  input  keyStrobe_t       strobe,
  input  logic [WIDTH-1:0] seedIn,
  output logic             lastStage
);
  logic [WIDTH-1:0] shiftReg;
  logic [WIDTH-1:0] loadValue;
  logic [WIDTH-1:0] steppedValue;
  logic [WIDTH-1:0] tapTerms;
  logic             feedback;

  // One masked term per stage; the feedback is their parity.
  for (genvar g = 0; g < WIDTH; g++) begin : g_tap
    assign tapTerms[g] = shiftReg[g] & TAP_MASK[g];
  end

  assign feedback     = ^tapTerms;
  assign steppedValue = {shiftReg[WIDTH-2:0], feedback};
  assign loadValue    = (seedIn == '0) ? DEFAULT_SEED : seedIn;
  assign lastStage    = shiftReg[WIDTH-1];

  always_ff @(posedge clk) begin
    if (rst)              shiftReg <= DEFAULT_SEED;
    else if (strobe.load) shiftReg <= loadValue;
    else if (strobe.step) shiftReg <= steppedValue;
  end

  // R7
  nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
    shiftReg != '0);

  // R7
  zero_seed_default_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && seedIn == '0) |=> shiftReg == DEFAULT_SEED);

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !strobe.load) |=> shiftReg[WIDTH-1:1] == $past(shiftReg[WIDTH-2:0]));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.step && !strobe.load) |=> $stable(shiftReg));
endmodule

// File: rtl/keygen_control.sv
`timescale 1ns/1ps
module keygen_control
  import keygen_pkg::*;
#(
  parameter int SHORT_STEPS = 1,
  parameter int LONG_STEPS  = 2,
  localparam int CNT_W = $clog2(LONG_STEPS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       seedLoad,
  input  logic       seedFirst,
  input  logic       keyReady,
  input  logic       lastStage,
  output keyStrobe_t strobe,
  output logic       keyValid
);
  localparam logic [CNT_W-1:0] SHORT_REM = CNT_W'(SHORT_STEPS - 1);
  localparam logic [CNT_W-1:0] LONG_REM  = CNT_W'(LONG_STEPS - 1);
  localparam logic [CNT_W-1:0] PRIME_CNT = CNT_W'(1);

  logic             armed;
  logic [CNT_W-1:0] pendSteps;
  logic [CNT_W-1:0] nextPend;
  logic             fire;
  logic             busy;

  assign busy     = armed && (pendSteps != '0);
  assign keyValid = armed && (pendSteps == '0);
  assign fire     = keyValid && keyReady;

  // The first step of a bit's budget happens in its consume cycle.
  assign strobe.load = seedLoad;
  assign strobe.step = !seedLoad && (busy || fire);

  always_comb begin
    nextPend = pendSteps;
    if (seedLoad)  nextPend = seedFirst ? '0 : PRIME_CNT;
    else if (busy) nextPend = pendSteps - 1'b1;
    else if (fire) nextPend = lastStage ? LONG_REM : SHORT_REM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      pendSteps <= '0;
    end else begin
      armed     <= armed | seedLoad;
      pendSteps <= nextPend;
    end
  end

  // R1
  arm_by_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(seedLoad));

  // R5
  pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pendSteps <= LONG_REM);
endmodule

// File: rtl/selfdec_keygen.sv
`timescale 1ns/1ps
module selfdec_keygen
  import keygen_pkg::*;
#(
  parameter int              WIDTH        = 5,
  parameter logic [WIDTH-1:0] TAP_MASK     = 5'b11110,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 5'b00001,
  parameter int              SHORT_STEPS  = 1,
  parameter int              LONG_STEPS   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedIn,
  input  logic             seedFirst,
  input  logic             keyReady,
  output logic             keyBit,
  output logic             keyValid
);
  keyStrobe_t strobe;
  logic       lastStage;

  keygen_control #(
    .SHORT_STEPS(SHORT_STEPS),
    .LONG_STEPS (LONG_STEPS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .seedLoad (seedLoad),
    .seedFirst(seedFirst),
    .keyReady (keyReady),
    .lastStage(lastStage),
    .strobe   (strobe),
    .keyValid (keyValid)
  );

  keygen_datapath #(
    .WIDTH       (WIDTH),
    .TAP_MASK    (TAP_MASK),
    .DEFAULT_SEED(DEFAULT_SEED)
  ) u_data (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .seedIn   (seedIn),
    .lastStage(lastStage)
  );

  assign keyBit = lastStage;

  // R3
  seed_first_chk: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedFirst && seedIn != '0) |=> (keyValid && keyBit == $past(seedIn[WIDTH-1])));

  // R4
  delayed_first_chk: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && !seedFirst) |=> !keyValid);

  // R5
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    (keyValid && keyReady && !seedLoad && !keyBit) |=> keyValid);

  // R5
  two_step_chk: assert property (@(posedge clk) disable iff (rst)
    (keyValid && keyReady && !seedLoad && keyBit) |=> !keyValid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (keyValid && !keyReady && !seedLoad) |=> (keyValid && $stable(keyBit)));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && keyValid && keyReady && seedFirst) |=> keyValid);
endmodule

// File: tb/sim_selfdec_keygen.sv
`timescale 1ns/1ps
module sim_selfdec_keygen;
  localparam logic [4:0]  DEF_SEED = 5'b00001;
  localparam logic [0:19] EXP20    = 20'b11101010000110110011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seedLoad = 1'b0;
  logic [4:0] seedIn = '0;
  logic       seedFirst = 1'b0;
  logic       keyReady = 1'b0;
  logic       keyBit;
  logic       keyValid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench model of the register and step budget.
  logic [4:0] mState = DEF_SEED;
  int         mPend = 0;
  bit         mArmed = 0;

  logic lastFire = 0;
  logic lastBitSeen = 0;
  logic lastValidSeen = 0;

  selfdec_keygen u0 (
    .clk      (clk),
    .rst      (rst),
    .seedLoad (seedLoad),
    .seedIn   (seedIn),
    .seedFirst(seedFirst),
    .keyReady (keyReady),
    .keyBit   (keyBit),
    .keyValid (keyValid)
  );

  always #10 clk = ~clk;

  function automatic logic [4:0] stepModel(input logic [4:0] s);
    return {s[3:0], s[1] ^ s[2] ^ s[3] ^ s[4]};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare outputs at a falling edge, then drive the inputs for the next rising edge.
  task automatic cyc(input bit ld, input logic [4:0] sd, input bit md, input bit rdy,
                     input string tag);
    bit expV;
    logic b;
    @(negedge clk);
    expV = mArmed && (mPend == 0);
    check(tag, int'(keyValid), int'(expV));
    if (expV) check(tag, int'(keyBit), int'(mState[4]));
    lastValidSeen = keyValid;
    lastBitSeen   = keyBit;
    lastFire      = keyValid && rdy && !ld;
    seedLoad  = ld;
    seedIn    = sd;
    seedFirst = md;
    keyReady  = rdy;
    if (ld) begin
      mState = (sd == 5'b0) ? DEF_SEED : sd;
      mPend  = md ? 0 : 1;
      mArmed = 1;
    end else if (mArmed && mPend > 0) begin
      mState = stepModel(mState);
      mPend--;
    end else if (expV && rdy) begin
      b      = mState[4];
      mState = stepModel(mState);
      mPend  = b ? 1 : 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [0:19] got;
    int nBits;
    int cycles;
    void'($urandom(32'h5eed1234));

    // R1: reset state and idle until the first load
    repeat (3) @(negedge clk);
    check("R1", int'(keyValid), 0);
    rst = 1'b0;
    repeat (4) cyc(0, 5'b0, 1, 1, "R1");

    // R3 and R5: known stream from seed 11111
    cyc(1, 5'b11111, 1, 1, "R3");
    nBits = 0;
    cycles = 0;
    got = '0;
    while (nBits < 20) begin
      cyc(0, 5'b0, 1, 1, "R5");
      cycles++;
      if (lastFire) begin
        got[nBits] = lastBitSeen;
        nBits++;
      end
    end
    for (int i = 0; i < 20; i++) check("R3", int'(got[i]), int'(EXP20[i]));
    check("R5", cycles, 30);

    // R6: stall holds bit and valid
    cyc(1, 5'b10110, 1, 0, "R6");
    repeat (5) cyc(0, 5'b0, 1, 0, "R6");
    check("R6", int'(lastValidSeen), 1);
    check("R6", int'(lastBitSeen), 1);
    cyc(0, 5'b0, 1, 1, "R6");

    // R4: one step before the first bit
    cyc(1, 5'b10000, 0, 1, "R4");
    cyc(0, 5'b0, 0, 1, "R4");
    check("R4", int'(lastValidSeen), 0);
    cyc(0, 5'b0, 0, 1, "R4");
    check("R4", int'(lastValidSeen), 1);
    check("R4", int'(lastBitSeen), 0);

    // R9: mode changes outside a load do nothing
    cyc(1, 5'b10000, 1, 1, "R9");
    cyc(0, 5'b0, 0, 1, "R9");
    check("R9", int'(lastValidSeen), 1);
    check("R9", int'(lastBitSeen), 1);
    repeat (10) cyc(0, 5'b0, 0, 1, "R9");

    // R7: zero seed takes the default
    cyc(1, 5'b00000, 1, 0, "R7");
    cyc(0, 5'b0, 1, 0, "R7");
    check("R7", int'(lastValidSeen), 1);
    check("R7", int'(lastBitSeen), 0);
    repeat (40) cyc(0, 5'b0, 1, 1, "R7");

    // R8: load collides with a consumed bit
    cyc(1, 5'b00111, 1, 1, "R8");
    cyc(1, 5'b10000, 1, 1, "R8");
    check("R8", int'(lastValidSeen), 1);
    check("R8", int'(lastBitSeen), 0);
    cyc(0, 5'b0, 1, 1, "R8");
    check("R8", int'(lastValidSeen), 1);
    check("R8", int'(lastBitSeen), 1);
    cyc(0, 5'b0, 1, 1, "R8");
    check("R8", int'(lastValidSeen), 0);

    // R2: random stall, load and mode traffic against the model
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 100) < 2, 5'($urandom), 1'($urandom),
          ($urandom % 10) < 7, "R2");
    end

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule